// File: doc/BRIEF.md
# Serial Polynomial Signature Analyzer

This block compresses a serial bit stream into a 5-bit signature. It treats the stream as the coefficients of a polynomial and divides it by the fixed divisor P(x) = 1 + x^2 + x^4 + x^5. The divider is a 5-stage shift register with the feedback XORs placed between stages. The first bit accepted is the highest-degree coefficient. After each accepted bit the register holds the remainder of the stream received so far. The bit that leaves the top stage on that cycle is the next quotient coefficient.

A test controller streams the responses of a circuit under test into `din`, marking each bit with `vld` while `en` is high. When the stream ends, it reads the signature from `rem_o`. The quotient stream is available bit by bit on `quo_o`. Over n stages, a faulty stream maps to the same signature with a probability of about 1/2^n. A synchronous `clr` starts a new compaction without using the reset.

Top module: `sig_poly_divider`

## Requirements
- R1: While reset is asserted and after it is released, before any bit is accepted, `rem_o` reads 0 and `quo_o` reads 0.
- R2: `rem_o[i]` holds stage r_i. On an accepted cycle (`en`=1, `vld`=1, `clr`=0), the stages update as follows: r0 takes `din` XOR r4, r1 takes r0, r2 takes r1 XOR r4, r3 takes r2, r4 takes r3 XOR r4. The result shows on `rem_o` after that clock edge.
- R3: On a cycle with `clr`=0 where `en` or `vld` is low, `din` is ignored and both `rem_o` and `quo_o` keep their values.
- R4: After an accepted cycle, `quo_o` equals the value `rem_o[4]` had before that edge. This is the quotient coefficient shifted out.
- R5: `clr`=1 sets `rem_o` and `quo_o` to 0 at the next clock edge, whatever the values of `en`, `vld` and `din`.
- R6: Starting from zero, the bits 1,1,1,1,0,1,0,1 are fed in that order. `rem_o` then reads 5'b00001 after the first bit, 5'b11110 after the fifth and 5'b10100 after the eighth. `quo_o` reads 1, 0, 1 after the sixth, seventh and eighth bits.
- R7: For any stream G accepted since the last clear, `rem_o` equals G mod P(x) over GF(2). With Q formed from the `quo_o` values of the accepted cycles, oldest first as the highest degree, P·Q + R = G.
- R8: After `clr`, compaction restarts as if the register were fresh. A stream fed after a clear gives the same signature as the same stream fed after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of remainder and quotient bit |
| en | input | 1 | Block enable |
| vld | input | 1 | Data-valid strobe for `din` |
| din | input | 1 | Serial stream bit, highest degree first |
| rem_o | output | 5 | Remainder (signature), bit i = stage r_i |
| quo_o | output | 1 | Quotient bit shifted out on the last accepted cycle |

## Verification
The bench checks the worked eight-bit stream at its intermediate states and at its end. A divider with a misplaced tap gives a different remainder from the sixth bit on, because that is where the top stage first feeds back. It holds `en` and `vld` low one at a time while toggling `din`. A design that gated on only one of them would absorb a stray bit and shift the signature.

It issues `clr` together with a valid strobe. A design with the wrong priority would load one bit instead of zero. Long random streams with gaps and mid-stream clears are checked against polynomial long division. The identity P·Q + R = G is checked from the observed quotient bits, so a quotient that is off by one cycle breaks the product.

// File: rtl/sig_pkg.sv
package sig_pkg;
  // number of divider stages (degree of the divisor)
  parameter int SIG_W = 5;
  // low coefficients of the divisor; x^SIG_W is implicit
  // bit i = coefficient of x^i : 1 + x^2 + x^4
  parameter logic [SIG_W-1:0] SIG_POLY = 5'b10101;
  typedef logic [SIG_W-1:0] sig_t;
endpackage

// File: rtl/sig_rst_sync.sv
module sig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/sig_div_step.sv
module sig_div_step #(
  parameter int               W    = sig_pkg::SIG_W,
  parameter logic [W-1:0]     POLY = sig_pkg::SIG_POLY
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt,
  output logic         shout
);
  logic fb;
  logic [W:0] chain;

  // feedback is the stage leaving the top; it is also the quotient bit
  assign fb    = cur[W-1];
  assign shout = fb;
  assign chain = {cur, din};

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (POLY[i]) begin : g_tap
      assign nxt[i] = chain[i] ^ fb;
    end else begin : g_pass
      assign nxt[i] = chain[i];
    end
  end
endmodule

// File: rtl/sig_state_reg.sv
module sig_state_reg #(
  parameter int W = sig_pkg::SIG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d_rem,
  input  logic         d_quo,
  output logic [W-1:0] q_rem,
  output logic         q_quo
);
  logic [W-1:0] rem_nxt;
  logic         quo_nxt;
  logic         ce;

  // clock enable written out: only a clear or a load moves the state
  assign ce = clr | ld;

  always_comb begin
    rem_nxt = q_rem;
    quo_nxt = q_quo;
    if (clr) begin
      rem_nxt = '0;
      quo_nxt = 1'b0;
    end else if (ld) begin
      rem_nxt = d_rem;
      quo_nxt = d_quo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rem <= '0;
      q_quo <= 1'b0;
    end else if (ce) begin
      q_rem <= rem_nxt;
      q_quo <= quo_nxt;
    end
  end
endmodule

// File: rtl/sig_poly_divider.sv
module sig_poly_divider (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       vld,
  input  logic       din,
  output logic [4:0] rem_o,
  output logic       quo_o
);
  import sig_pkg::*;

  logic rst_q;
  logic take;
  sig_t cur_rem;
  sig_t step_rem;
  logic step_quo;

  sig_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign take = en & vld;

  sig_div_step #(.W(SIG_W), .POLY(SIG_POLY)) u_step (
    .cur   (cur_rem),
    .din   (din),
    .nxt   (step_rem),
    .shout (step_quo)
  );

  sig_state_reg #(.W(SIG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (clr),
    .ld    (take),
    .d_rem (step_rem),
    .d_quo (step_quo),
    .q_rem (cur_rem),
    .q_quo (quo_o)
  );

  assign rem_o = cur_rem;
endmodule

// File: rtl/sig_poly_divider_chk.sv
module sig_poly_divider_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         en,
  input logic         vld,
  input logic [W-1:0] rem,
  input logic         quo
);
  // R1: held at zero while the internal reset is active
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (rem == '0 && !quo));

  // R3: no strobe, no clear -> state frozen
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(en && vld)) |=> ($stable(rem) && $stable(quo)));

  // R5: clear wins over any strobe
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem == '0 && !quo));

  // R4: quotient bit is the old top stage
  p_quo_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && vld) |=> (quo == $past(rem[W-1])));

  // R2: untapped stages shift straight up
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && vld) |=> (rem[1] == $past(rem[0]) && rem[3] == $past(rem[2])));
endmodule

bind sig_poly_divider sig_poly_divider_chk #(.W(5)) u_chk (
  .clk   (clk),
  .rst_n (rst_q),
  .clr   (clr),
  .en    (en),
  .vld   (vld),
  .rem   (rem_o),
  .quo   (quo_o)
);

// File: tb/sig_poly_divider_test.sv
module sig_poly_divider_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr, en, vld, din;
  logic [4:0] rem_o;
  logic       quo_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference: the whole accepted stream, highest degree first
  bit   stream[$];
  int   m_rem = 0;
  bit   m_quo = 0;
  longint q_obs = 0;

  always #10 clk = ~clk; // 50 MHz

  sig_poly_divider uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .vld(vld),
    .din(din), .rem_o(rem_o), .quo_o(quo_o)
  );

  // long division of the stored stream by 1+x^2+x^4+x^5 (0b110101)
  task automatic divide(output int r, output bit qlast);
    r = 0; qlast = 0;
    foreach (stream[k]) begin
      r = (r << 1) | int'(stream[k]);
      qlast = (r >= 32);
      if (qlast) r = r ^ 53;
    end
  endtask

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit e, input bit v, input bit d, input string req);
    int r; bit q;
    clr = c; en = e; vld = v; din = d;
    @(posedge clk);
    if (c) begin
      stream.delete(); m_rem = 0; m_quo = 0;
    end else if (e && v) begin
      stream.push_back(d);
      divide(r, q);
      m_rem = r; m_quo = q;
    end
    @(negedge clk);
    chk({req, " rem"}, rem_o, m_rem[4:0]);
    chk({req, " quo"}, {4'b0, quo_o}, {4'b0, m_quo});
    if (!c && e && v) q_obs = (q_obs << 1) | longint'(quo_o);
    if (c) q_obs = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit ex[8] = '{1,1,1,1,0,1,0,1};
    rst_n = 1'b0; clr = 0; en = 0; vld = 0; din = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset rem", rem_o, 5'b0);
    chk("R1 in reset quo", {4'b0, quo_o}, 5'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release rem", rem_o, 5'b0);
    chk("R1 after release quo", {4'b0, quo_o}, 5'b0);

    // R6 worked stream, with explicit expected states
    for (int k = 0; k < 8; k++) begin
      cyc(0, 1, 1, ex[k], "R6 R2");
      if (k == 0) chk("R6 after bit 1", rem_o, 5'b00001);
      if (k == 4) chk("R6 after bit 5", rem_o, 5'b11110);
      if (k == 5) chk("R6 quo bit 6", {4'b0, quo_o}, 5'd1);
      if (k == 6) chk("R6 quo bit 7", {4'b0, quo_o}, 5'd0);
      if (k == 7) begin
        chk("R6 after bit 8", rem_o, 5'b10100);
        chk("R6 quo bit 8", {4'b0, quo_o}, 5'd1);
      end
    end

    // R3: strobes with one qualifier missing, din toggling
    for (int k = 0; k < 6; k++) begin
      logic [4:0] keep_r; logic keep_q;
      keep_r = rem_o; keep_q = quo_o;
      cyc(0, k[0], ~k[0], k[1], "R3");
      chk("R3 hold rem", rem_o, keep_r);
      chk("R3 hold quo", {4'b0, quo_o}, {4'b0, keep_q});
    end

    // R5: clear together with a valid strobe
    cyc(0, 1, 1, 1, "R4");
    cyc(1, 1, 1, 1, "R5");
    chk("R5 clear rem", rem_o, 5'b0);
    chk("R5 clear quo", {4'b0, quo_o}, 5'b0);

    // R8: same worked stream after a clear
    for (int k = 0; k < 8; k++) cyc(0, 1, 1, ex[k], "R8");
    chk("R8 restart signature", rem_o, 5'b10100);

    // R7: P*Q + R == G on a 40-bit stream
    cyc(1, 0, 0, 0, "R5");
    begin
      longint g = 0, prod = 0;
      for (int k = 0; k < 40; k++) begin
        bit b = bit'($urandom_range(0, 1));
        g = (g << 1) | longint'(b);
        cyc(0, 1, 1, b, "R7 R4");
        if ($urandom_range(0, 3) == 0) cyc(0, 0, 1, ~b, "R3");
      end
      for (int k = 0; k < 40; k++)
        if (q_obs[k]) prod = prod ^ (longint'(53) << k);
      prod = prod ^ longint'(rem_o);
      vectors++;
      if (prod != g) begin
        miscompares++;
        $display("FAIL R7 identity: got %h expected %h", prod, g);
      end
    end

    // long random run with gaps and occasional clears
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 39);
      cyc(sel == 0, sel != 1, sel != 2, bit'($urandom_range(0, 1)), "R2 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule